// File: doc/BRIEF.md
# Limp-Home Safe-State Controller

This block governs the operating mode of a multi-channel output switch. In normal operation every channel enable follows a host-written output register. When an external limp-home pin goes high, or when the host stops refreshing an enabled watchdog, the block moves into a safe mode. In that mode each channel enable is taken from a separate safe-state register. The host's own output pattern is kept untouched, so it comes back into force on exit.

Safe mode can only be entered from the active mode. Leaving it takes two things: the synchronised pin must be low, and the host must write a one to the limp status bit of the fault word. A logic-supply undervoltage flag is shown in the fault word but never changes the mode. All configuration registers keep their contents across mode changes. Only a reset returns them to their defaults.

The host reaches the block through a simple single-cycle register-write port. Serial framing, analog sensing and the power stage are outside this block and appear here only as strobes and flags.

Top module: `lh_safe_ctrl`

## Requirements
- R1: Reset sets the following: mode active, `safe_mode_o`=0, all channel enables 0, output and safe-state registers 0, watchdog fault cleared, and watchdog timeout `WD_DEFAULT` cycles.
- R2: In active mode, a write to address 0 stores `wr_data_i[NCH-1:0]` in the output register. `ch_en_o` shows the new value after the edge that takes the write.
- R3: A high level on `lh_pin_i` passes through a two-flop synchroniser. The mode becomes safe on the third rising edge after the pin rises and is still active after the second.
- R4: With `wd_en_i` high in active mode, the watchdog counts down a timeout L (address 3, `wr_data_i[CNT_W-1:0]`). After L edges with no `wd_tick_i` the mode is still active. On edge L+1 it becomes safe. A tick reloads the full timeout. With `wd_en_i` low the watchdog never expires.
- R5: In safe mode, `ch_en_o` equals the safe-state register, which is written at address 1 from `wr_data_i[NCH-1:0]`.
- R6: Safe mode is left on an edge where the synchronised pin is low and a write to address 2 has `wr_data_i[0]`=1. Such a write while the synchronised pin is high is ignored, and the mode stays safe. Bit 0 of `fault_o` reads 1 exactly while in safe mode.
- R7: `fault_o[2]` mirrors `vdd_uv_i`. Undervoltage alone never leaves active mode.
- R8: A watchdog expiry sets the sticky `fault_o[1]`. It is cleared by a write to address 2 with `wr_data_i[1]`=1, which does not by itself change the mode.
- R9: Writes to the output and safe-state registers are accepted in either mode. The output register written during safe mode appears on `ch_en_o` after exit.
- R10: The watchdog holds no count in safe mode or while disabled. After exit from safe mode a full timeout L must pass again before the next expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lh_pin_i | input | 1 | Asynchronous limp-home request pin |
| wd_en_i | input | 1 | Watchdog enable |
| wd_tick_i | input | 1 | Host watchdog refresh strobe |
| vdd_uv_i | input | 1 | Logic-supply undervoltage flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 output, 1 safe-state, 2 fault clear, 3 timeout) |
| wr_data_i | input | DW | Register write data |
| ch_en_o | output | NCH | Per-channel output enables |
| safe_mode_o | output | 1 | High while in safe mode |
| fault_o | output | 3 | Fault word: bit0 limp status, bit1 watchdog fault, bit2 undervoltage |

## Verification
The bench builds the block with four channels, an 8-bit data port and an 8-bit timeout, and keeps the 12-cycle default. A timeout of 5 is written early in the run, so expiry, tick reload and the restart after exit each happen within a handful of cycles and can be checked at the exact edge. The default value is still exercised after a later reset. Four channels give enough distinct patterns to tell the host output pattern from the safe-state pattern, and to see that the host pattern written during safe mode comes back on exit.

// File: rtl/lh_pkg.sv
// Package: shared mode type, register map and fault-word bit positions
// for the limp-home safe-state controller.
package lh_pkg;
    typedef enum logic {
        LH_ACTIVE = 1'b0,
        LH_SAFE   = 1'b1
    } lh_mode_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_OUT  = 2'd0;
    localparam logic [ADDR_W-1:0] REG_SAFE = 2'd1;
    localparam logic [ADDR_W-1:0] REG_FLT  = 2'd2;
    localparam logic [ADDR_W-1:0] REG_WDL  = 2'd3;

    localparam int FLT_W    = 3;
    localparam int FLT_LIMP = 0;
    localparam int FLT_WDOG = 1;
    localparam int FLT_UV   = 2;
endpackage

// File: rtl/lh_sync.sv
// Module: lh_sync
// Multi-flop synchroniser for one asynchronous level input.
// Assumes STAGES >= 2 and that the input stays steady for more than one clock.
module lh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lh_regs.sv
// Module: lh_regs
// Host-writable configuration: the output pattern, the safe-state pattern and
// the watchdog timeout. It also decodes the write-one-to-clear strobes for the
// fault word. Assumes NCH <= DW and CNT_W <= DW. The contents change only
// on a write or on reset.
module lh_regs
    import lh_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DW         = 8,
    parameter int CNT_W      = 8,
    parameter int WD_DEFAULT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [NCH-1:0]    out_q,
    output logic [NCH-1:0]    safe_q,
    output logic [CNT_W-1:0]  limit_q,
    output logic              clr_limp,
    output logic              clr_wdog
);
    localparam logic [CNT_W-1:0] LIMIT_RST = CNT_W'(WD_DEFAULT);

    // Store register writes; nothing else changes the contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            safe_q  <= '0;
            limit_q <= LIMIT_RST;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                REG_OUT:  out_q   <= wr_data_i[NCH-1:0];
                REG_SAFE: safe_q  <= wr_data_i[NCH-1:0];
                REG_WDL:  limit_q <= wr_data_i[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Decode the write-one-to-clear requests on the fault word.
    always_comb begin
        clr_limp = wr_en_i && (wr_addr_i == REG_FLT) && wr_data_i[FLT_LIMP];
        clr_wdog = wr_en_i && (wr_addr_i == REG_FLT) && wr_data_i[FLT_WDOG];
    end
endmodule

// File: rtl/lh_wdog.sv
// Module: lh_wdog
// Host refresh watchdog. While run_i is high the counter moves down by one each
// cycle, and a tick reloads it. While run_i is low it is held at the limit.
// expire_o is high while running with the counter at zero and no tick present.
module lh_wdog #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Reload when idle or refreshed, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= limit_i;
        else if (!run_i || tick_i)  cnt_q <= limit_i;
        else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = run_i && !tick_i && (cnt_q == '0);
endmodule

// File: rtl/lh_chan_mux.sv
// Module: lh_chan_mux
// Per-channel selection between the host output pattern and the safe pattern.
// Purely combinational; one selector per channel.
module lh_chan_mux #(
    parameter int NCH = 4
) (
    input  logic           safe_i,
    input  logic [NCH-1:0] host_i,
    input  logic [NCH-1:0] safe_pat_i,
    output logic [NCH-1:0] ch_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_o[g] = safe_i ? safe_pat_i[g] : host_i[g];
    end
endmodule

// File: rtl/lh_safe_ctrl.sv
// Module: lh_safe_ctrl
// Top of the limp-home safe-state controller. A two-state machine (active/safe)
// enters safe only from active, on the synchronised pin or a watchdog expiry.
// It leaves only when the synchronised pin is low and the host clears the limp
// bit. Undervoltage is reported and never changes the mode. Assumes the pin is
// asynchronous and all other inputs are synchronous to clk.
module lh_safe_ctrl
    import lh_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DW          = 8,
    parameter int CNT_W       = 8,
    parameter int WD_DEFAULT  = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lh_pin_i,
    input  logic              wd_en_i,
    input  logic              wd_tick_i,
    input  logic              vdd_uv_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [NCH-1:0]    ch_en_o,
    output logic              safe_mode_o,
    output logic [FLT_W-1:0]  fault_o
);
    lh_mode_e         mode_q;
    logic             pin_s;
    logic             wd_expire;
    logic             wd_flt_q;
    logic             clr_limp;
    logic             clr_wdog;
    logic [NCH-1:0]   out_q;
    logic [NCH-1:0]   safe_q;
    logic [CNT_W-1:0] limit_q;

    lh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lh_pin_i),
        .sync_o  (pin_s)
    );

    lh_regs #(.NCH(NCH), .DW(DW), .CNT_W(CNT_W), .WD_DEFAULT(WD_DEFAULT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .out_q     (out_q),
        .safe_q    (safe_q),
        .limit_q   (limit_q),
        .clr_limp  (clr_limp),
        .clr_wdog  (clr_wdog)
    );

    lh_wdog #(.CNT_W(CNT_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (wd_en_i && (mode_q == LH_ACTIVE)),
        .tick_i   (wd_tick_i),
        .limit_i  (limit_q),
        .expire_o (wd_expire)
    );

    // Mode machine: enter safe only from active, leave only on pin low plus clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LH_ACTIVE;
        end else begin
            case (mode_q)
                LH_ACTIVE: if (pin_s || wd_expire)  mode_q <= LH_SAFE;
                LH_SAFE:   if (clr_limp && !pin_s)  mode_q <= LH_ACTIVE;
                default:                            mode_q <= LH_ACTIVE;
            endcase
        end
    end

    // Sticky watchdog fault flag; a new expiry wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         wd_flt_q <= 1'b0;
        else if (wd_expire) wd_flt_q <= 1'b1;
        else if (clr_wdog)  wd_flt_q <= 1'b0;
    end

    lh_chan_mux #(.NCH(NCH)) u_mux (
        .safe_i     (mode_q == LH_SAFE),
        .host_i     (out_q),
        .safe_pat_i (safe_q),
        .ch_o       (ch_en_o)
    );

    // Assemble the mode indication and the fault word.
    always_comb begin
        safe_mode_o       = (mode_q == LH_SAFE);
        fault_o           = '0;
        fault_o[FLT_LIMP] = (mode_q == LH_SAFE);
        fault_o[FLT_WDOG] = wd_flt_q;
        fault_o[FLT_UV]   = vdd_uv_i;
    end
endmodule

// File: rtl/lh_safe_ctrl_chk.sv
// Module: lh_safe_ctrl_chk
// Property checker for lh_safe_ctrl, attached by bind. past_ok gates every
// property that looks one cycle back, so no check reaches into reset.
module lh_safe_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mode_safe,
    input logic           pin_s,
    input logic           wd_expire,
    input logic           wd_en,
    input logic           wd_flt,
    input logic [NCH-1:0] ch_en,
    input logic           wr_en,
    input logic [1:0]     wr_addr,
    input logic           wr_bit0
);
    logic past_ok;

    // Mark the first cycle after reset whose previous cycle is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    logic clr_req;
    logic out_wr;
    logic safe_wr;
    assign clr_req = wr_en && (wr_addr == 2'd2) && wr_bit0;
    assign out_wr  = wr_en && (wr_addr == 2'd0);
    assign safe_wr = wr_en && (wr_addr == 2'd1);

    AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(mode_safe)) |-> ($past(pin_s) || $past(wd_expire))); // R3
    AST_EXIT_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(mode_safe)) |-> $past(clr_req)); // R6
    AST_EXIT_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(mode_safe)) |-> !$past(pin_s)); // R6
    AST_WDOG_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |-> (!mode_safe && wd_en)); // R10
    AST_WDFLT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(wd_flt)) |-> $past(wd_expire)); // R8
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !mode_safe && !$past(mode_safe) && !$past(out_wr)) |-> $stable(ch_en)); // R2
    AST_SAFE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode_safe && $past(mode_safe) && !$past(safe_wr)) |-> $stable(ch_en)); // R5
endmodule

bind lh_safe_ctrl lh_safe_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_safe (safe_mode_o),
    .pin_s     (pin_s),
    .wd_expire (wd_expire),
    .wd_en     (wd_en_i),
    .wd_flt    (fault_o[1]),
    .ch_en     (ch_en_o),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_bit0   (wr_data_i[0])
);

// File: tb/lh_safe_ctrl_bench.sv
// Bench for lh_safe_ctrl: a vector table walked by one loop, then directed
// reset and default-timeout tests. Inputs change 1 time unit after a rising
// edge, and outputs are sampled there too.
module lh_safe_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int CW  = 8;
    localparam int WDD = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lh_pin = 1'b0;
    logic          wd_en = 1'b0;
    logic          wd_tick = 1'b0;
    logic          vdd_uv = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NCH-1:0] ch_en;
    logic          safe_mode;
    logic [2:0]    fault;

    int total = 0;
    int bad   = 0;

    lh_safe_ctrl #(.NCH(NCH), .DW(DW), .CNT_W(CW), .WD_DEFAULT(WDD)) u_lh_safe_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lh_pin_i    (lh_pin),
        .wd_en_i     (wd_en),
        .wd_tick_i   (wd_tick),
        .vdd_uv_i    (vdd_uv),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .ch_en_o     (ch_en),
        .safe_mode_o (safe_mode),
        .fault_o     (fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       wr;
        logic [1:0] addr;
        logic [7:0] data;
        logic       pin;
        logic       wden;
        logic       tick;
        logic       uv;
        logic [7:0] cyc;
        logic [3:0] ech;
        logic       emode;
        logic [2:0] eflt;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    // fields: wr addr data pin wden tick uv cycles | exp ch mode fault | req
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd0, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  4'h5, 1'b0, 3'b000, 4'd2},  // R2 host pattern
        '{1'b1, 2'd1, 8'h0A, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  4'h5, 1'b0, 3'b000, 4'd5},  // R5 safe pattern hidden
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2,  4'h5, 1'b0, 3'b000, 4'd3},  // R3 two edges: still active
        '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  4'hA, 1'b1, 3'b001, 4'd3},  // R3 third edge: safe
        '{1'b1, 2'd2, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  4'hA, 1'b1, 3'b001, 4'd6},  // R6 clear ignored, pin high
        '{1'b1, 2'd0, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  4'hA, 1'b1, 3'b001, 4'd9},  // R9 write in safe
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'd3,  4'hA, 1'b1, 3'b101, 4'd6},  // R6 pin low alone: stays
        '{1'b1, 2'd2, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  4'h3, 1'b0, 3'b100, 4'd9},  // R9 exit restores host
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 4'h3, 1'b0, 3'b100, 4'd7},  // R7 uv no entry
        '{1'b1, 2'd3, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  4'h3, 1'b0, 3'b000, 4'd4},  // R4 timeout 5
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5,  4'h3, 1'b0, 3'b000, 4'd4},  // R4 L edges: active
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1,  4'h3, 1'b0, 3'b000, 4'd4},  // R4 tick reloads
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5,  4'h3, 1'b0, 3'b000, 4'd4},  // R4 full L again
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,  4'hA, 1'b1, 3'b011, 4'd8},  // R8 expiry: safe + flag
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8,  4'hA, 1'b1, 3'b011, 4'd10}, // R10 frozen in safe
        '{1'b1, 2'd2, 8'h02, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,  4'hA, 1'b1, 3'b001, 4'd8},  // R8 clear wd flag only
        '{1'b1, 2'd2, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,  4'h3, 1'b0, 3'b000, 4'd6},  // R6 exit
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5,  4'h3, 1'b0, 3'b000, 4'd10}, // R10 full timeout restarts
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 4'h3, 1'b0, 3'b000, 4'd4},  // R4 disabled: no expiry
        '{1'b1, 2'd0, 8'h0C, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  4'hC, 1'b0, 3'b000, 4'd2}   // R2 second pattern
    };

    task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input int req, input logic [3:0] ech, input logic em, input logic [2:0] ef);
        chk(req, "ch_en", 8'(ch_en), 8'(ech));
        chk(req, "safe_mode", 8'(safe_mode), 8'(em));
        chk(req, "fault", 8'(fault), 8'(ef));
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        edges(3);
        chk_all(1, 4'h0, 1'b0, 3'b000); // R1 state while in reset
        rst_n = 1'b1;
        edges(1);
        chk_all(1, 4'h0, 1'b0, 3'b000); // R1 state after reset

        for (int i = 0; i < NV; i++) begin
            wr_en   = TBL[i].wr;
            wr_addr = TBL[i].addr;
            wr_data = TBL[i].data;
            lh_pin  = TBL[i].pin;
            wd_en   = TBL[i].wden;
            wd_tick = TBL[i].tick;
            vdd_uv  = TBL[i].uv;
            @(posedge clk);
            #1;
            wr_en   = 1'b0;
            wd_tick = 1'b0;
            edges(int'(TBL[i].cyc) - 1);
            chk_all(int'(TBL[i].req), TBL[i].ech, TBL[i].emode, TBL[i].eflt);
        end

        // R1: reset restores the default timeout and clears registers
        rst_n = 1'b0;
        edges(2);
        chk_all(1, 4'h0, 1'b0, 3'b000);
        rst_n = 1'b1;
        wd_en = 1'b1;
        edges(WDD);
        chk_all(1, 4'h0, 1'b0, 3'b000); // R1 default L: still active
        edges(1);
        chk_all(4, 4'h0, 1'b1, 3'b011); // R4 expiry at L+1 with default

        // R3: reset with pin held high, entry again after synchroniser delay
        wd_en  = 1'b0;
        lh_pin = 1'b1;
        rst_n  = 1'b0;
        edges(2);
        chk_all(1, 4'h0, 1'b0, 3'b000); // R1 reset overrides pin
        rst_n = 1'b1;
        edges(2);
        chk_all(3, 4'h0, 1'b0, 3'b000); // R3 synchroniser delay after reset
        edges(1);
        chk_all(3, 4'h0, 1'b1, 3'b001); // R3 entry on third edge

        // R7: undervoltage flag alone in active mode
        lh_pin = 1'b0;
        edges(3);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
        edges(1);
        wr_en = 1'b0;
        vdd_uv = 1'b1;
        #1;
        chk_all(7, 4'h0, 1'b0, 3'b100); // R7 flag shown, mode active
        edges(4);
        chk_all(7, 4'h0, 1'b0, 3'b100); // R7 still active

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule